// File: doc/BRIEF.md
# Segmented Physical Address Former

This unit turns a segment and an offset into a flat physical address. The segment value is moved up by four bit positions, so each segment step is 16 bytes. The offset is then added, and the sum is truncated to a 20-bit result that covers a 1 MB space. Many different segment and offset pairs give the same physical location. For example, A000h:5677h and A111h:4567h both give A5677h.

There are two ways to supply the segment. A near access gives only an offset, and the segment comes from one of four base register values, picked by a two-bit access class. A far access carries its own segment, and that segment is used no matter what the class says. The four base values arrive as inputs, so the register file stays outside the block.

The result is registered. A request pulse produces a valid address one clock later. When there is no request, the last address stays on the output unchanged.

Top module: `seg_agu`

## Requirements
- R1: While reset is asserted and right after it is released, `valid_o` is 0 and `addr_o` is 0.
- R2: `valid_o` equals the value `req_i` had at the previous rising clock edge. Each request produces exactly one valid cycle, one clock later.
- R3: The result is (segment × 16 + offset) modulo 2^20. Any carry out of bit 19 is discarded, so FFFFh:FFFFh gives 0FFEFh and FFFFh:0010h gives 00000h.
- R4: For a near access with class 2'b00 (data), the segment is `ds_base_i`.
- R5: For a near access with class 2'b01 (code fetch), the segment is `cs_base_i`.
- R6: For a near access with class 2'b10 (stack), the segment is `ss_base_i`.
- R7: For a near access with class 2'b11 (extra), the segment is `es_base_i`.
- R8: When `far_i` is 1, the segment is `far_seg_i`, whatever the access class is.
- R9: In a cycle where `req_i` is 0, `addr_o` keeps its previous value, even if the segment, offset or class inputs change.
- R10: Two different pairs that point to the same location give the same address. A000h:5677h and A111h:4567h both give A5677h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; the inputs below are captured in this cycle |
| acc_class_i | input | 2 | Access class: 00 data, 01 code, 10 stack, 11 extra |
| far_i | input | 1 | 1 = use the explicit segment, 0 = use the class base |
| far_seg_i | input | 16 | Explicit segment for far accesses |
| ds_base_i | input | 16 | Data segment base value |
| cs_base_i | input | 16 | Code segment base value |
| ss_base_i | input | 16 | Stack segment base value |
| es_base_i | input | 16 | Extra segment base value |
| offset_i | input | 16 | Offset within the segment |
| valid_o | output | 1 | Address valid, one clock after the request |
| addr_o | output | 20 | Registered physical address |

## Verification
The bench uses the default widths: a 16-bit segment, a 16-bit offset and a shift of four, which makes the address 20 bits wide. At these widths, an all-ones segment plus a large offset carries out of bit 19, so the wrap case can be tested directly. The four base inputs carry different values in every vector, so a wrong class decode shows up as a wrong address. The two aliasing pairs are driven one after the other and must give the same result.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

  // Access class encoding decoded by the segment selector
  typedef enum logic [1:0] {
    ACC_DATA  = 2'b00,
    ACC_CODE  = 2'b01,
    ACC_STACK = 2'b10,
    ACC_EXTRA = 2'b11
  } acc_class_e;

  localparam int DEF_SEG_W = 16;
  localparam int DEF_OFF_W = 16;
  localparam int DEF_SHIFT = 4;

endpackage

// File: rtl/seg_agu_select.sv
module seg_agu_select
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = DEF_SEG_W
) (
  input  acc_class_e       acc_class_i,
  input  logic             far_i,
  input  logic [SEG_W-1:0] far_seg_i,
  input  logic [SEG_W-1:0] ds_base_i,
  input  logic [SEG_W-1:0] cs_base_i,
  input  logic [SEG_W-1:0] ss_base_i,
  input  logic [SEG_W-1:0] es_base_i,
  output logic [SEG_W-1:0] seg_o
);

  logic [SEG_W-1:0] near_seg;

  // Implicit base chosen by the access class
  always_comb begin
    unique case (acc_class_i)
      ACC_DATA:  near_seg = ds_base_i;
      ACC_CODE:  near_seg = cs_base_i;
      ACC_STACK: near_seg = ss_base_i;
      default:   near_seg = es_base_i;
    endcase
  end

  // An explicit segment wins over the implicit one
  assign seg_o = far_i ? far_seg_i : near_seg;

endmodule

// File: rtl/seg_agu_combine.sv
module seg_agu_combine #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              carry_o
);

  localparam int SUM_W = ADDR_W + 1;

  // Scale the segment into the address space (paragraph granularity)
  function automatic logic [SUM_W-1:0] scaled_seg(input logic [SEG_W-1:0] s);
    logic [SUM_W-1:0] w;
    w = '0;
    w[SHIFT +: SEG_W] = s;
    return w;
  endfunction

  // Zero-extend the offset to the sum width
  function automatic logic [SUM_W-1:0] wide_off(input logic [OFF_W-1:0] o);
    logic [SUM_W-1:0] w;
    w = '0;
    w[OFF_W-1:0] = o;
    return w;
  endfunction

  logic [SUM_W-1:0] full_sum;

  assign full_sum = scaled_seg(seg_i) + wide_off(off_i);
  // The carry out of the top address bit is dropped (wrap)
  assign phys_o   = full_sum[ADDR_W-1:0];
  assign carry_o  = full_sum[ADDR_W];

endmodule

// File: rtl/seg_agu_stage.sv
module seg_agu_stage #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] phys_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= phys_i;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(req_i));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(addr_o));

endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = DEF_SEG_W,
  parameter int OFF_W = DEF_OFF_W,
  parameter int SHIFT = DEF_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [1:0]             acc_class_i,
  input  logic                   far_i,
  input  logic [SEG_W-1:0]       far_seg_i,
  input  logic [SEG_W-1:0]       ds_base_i,
  input  logic [SEG_W-1:0]       cs_base_i,
  input  logic [SEG_W-1:0]       ss_base_i,
  input  logic [SEG_W-1:0]       es_base_i,
  input  logic [OFF_W-1:0]       offset_i,
  output logic                   valid_o,
  output logic [SEG_W+SHIFT-1:0] addr_o
);

  localparam int ADDR_W = SEG_W + SHIFT;

  // Named internal events for the checks below
  logic [SEG_W-1:0]  sel_seg;
  logic [ADDR_W-1:0] phys_addr;
  logic              addr_carry;
  acc_class_e        acc_class;

  assign acc_class = acc_class_e'(acc_class_i);

  seg_agu_select #(.SEG_W(SEG_W)) u_select (
    .acc_class_i (acc_class),
    .far_i       (far_i),
    .far_seg_i   (far_seg_i),
    .ds_base_i   (ds_base_i),
    .cs_base_i   (cs_base_i),
    .ss_base_i   (ss_base_i),
    .es_base_i   (es_base_i),
    .seg_o       (sel_seg)
  );

  seg_agu_combine #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT),
    .ADDR_W(ADDR_W)
  ) u_combine (
    .seg_i   (sel_seg),
    .off_i   (offset_i),
    .phys_o  (phys_addr),
    .carry_o (addr_carry)
  );

  seg_agu_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .phys_i  (phys_addr),
    .valid_o (valid_o),
    .addr_o  (addr_o)
  );

  // Reference sum written as multiply-and-add, independent of the combiner
  function automatic logic [ADDR_W-1:0] ref_addr(input logic [SEG_W-1:0] s,
                                                 input logic [OFF_W-1:0] o);
    logic [ADDR_W:0] t;
    t = ({{(SHIFT+1){1'b0}}, s} * (ADDR_W+1)'(2**SHIFT))
        + {{(ADDR_W+1-OFF_W){1'b0}}, o};
    return t[ADDR_W-1:0];
  endfunction

  p_far_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && far_i) |=> addr_o == ref_addr($past(far_seg_i), $past(offset_i)));

  p_near_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !far_i && acc_class_i == 2'b00)
      |=> addr_o == ref_addr($past(ds_base_i), $past(offset_i)));

  p_near_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !far_i && acc_class_i == 2'b01)
      |=> addr_o == ref_addr($past(cs_base_i), $past(offset_i)));

  p_near_stack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !far_i && acc_class_i == 2'b10)
      |=> addr_o == ref_addr($past(ss_base_i), $past(offset_i)));

  p_near_extra_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !far_i && acc_class_i == 2'b11)
      |=> addr_o == ref_addr($past(es_base_i), $past(offset_i)));

  // A carry out means the wrapped address sits below the scaled segment
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && addr_carry) |=> addr_o < ref_addr($past(sel_seg), '0));

endmodule

// File: tb/seg_agu_tb.sv
module seg_agu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0]  ty;
    logic        far;
    logic [15:0] fseg;
    logic [15:0] ds;
    logic [15:0] cs;
    logic [15:0] ss;
    logic [15:0] es;
    logic [15:0] off;
    logic [19:0] exp;
  } vec_t;

  // ty, far, fseg, ds, cs, ss, es, off, expected
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 1'b0, 16'h5555, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h5677, 20'hA5677}, // R4 R10
    '{2'b00, 1'b0, 16'h5555, 16'hA111, 16'h1234, 16'h2000, 16'hF000, 16'h4567, 20'hA5677}, // R10
    '{2'b01, 1'b0, 16'h5555, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h0010, 20'h12350}, // R5
    '{2'b10, 1'b0, 16'h5555, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'hFFFE, 20'h2FFFE}, // R6
    '{2'b11, 1'b0, 16'h5555, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h1234, 20'hF1234}, // R7
    '{2'b00, 1'b1, 16'hB800, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h0000, 20'hB8000}, // R8
    '{2'b10, 1'b1, 16'h0001, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h000F, 20'h0001F}, // R8
    '{2'b00, 1'b0, 16'h5555, 16'hFFFF, 16'h1234, 16'h2000, 16'hF000, 16'hFFFF, 20'h0FFEF}, // R3
    '{2'b11, 1'b1, 16'hFFFF, 16'hA000, 16'h1234, 16'h2000, 16'hF000, 16'h0010, 20'h00000}, // R3
    '{2'b01, 1'b0, 16'h5555, 16'hA000, 16'hFFFF, 16'h2000, 16'hF000, 16'h0011, 20'h00001}  // R3 R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  acc = 2'b00;
  logic        far = 1'b0;
  logic [15:0] fseg = '0, ds = '0, cs = '0, ss = '0, es = '0, off = '0;
  logic        valid;
  logic [19:0] addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .acc_class_i(acc), .far_i(far),
    .far_seg_i(fseg), .ds_base_i(ds), .cs_base_i(cs), .ss_base_i(ss),
    .es_base_i(es), .offset_i(off), .valid_o(valid), .addr_o(addr)
  );

  task automatic check(input string req_tag, input logic [19:0] act,
                       input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", req_tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic r);
    req = r; acc = v.ty; far = v.far; fseg = v.fseg;
    ds = v.ds; cs = v.cs; ss = v.ss; es = v.es; off = v.off;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 valid in reset", {19'd0, valid}, 20'd0);
    check("R1 addr in reset", addr, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {19'd0, valid}, 20'd0);
    check("R1 addr after release", addr, 20'd0);

    // Table walk: requests issued back to back, results one clock later
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i], 1'b1);
      @(negedge clk);
      check($sformatf("R2 valid vec %0d", i), {19'd0, valid}, 20'd1);
      check($sformatf("R3-vec %0d addr", i), addr, VEC[i].exp);
    end

    // R9: no request, all inputs change, address must hold
    apply(VEC[0], 1'b0);
    @(negedge clk);
    check("R2 valid drops", {19'd0, valid}, 20'd0);
    check("R9 hold addr", addr, VEC[NVEC-1].exp);
    apply(VEC[5], 1'b0);
    @(negedge clk);
    check("R9 hold addr after input change", addr, VEC[NVEC-1].exp);

    // R8: far ignores class for each class value
    for (int c = 0; c < 4; c++) begin
      apply(VEC[5], 1'b1);
      acc = c[1:0];
      @(negedge clk);
      check($sformatf("R8 far class %0d", c), addr, 20'hB8000);
    end

    // R10: aliasing pair again, after unrelated traffic
    apply(VEC[1], 1'b1);
    @(negedge clk);
    check("R10 alias second pair", addr, 20'hA5677);
    apply(VEC[0], 1'b1);
    @(negedge clk);
    check("R10 alias first pair", addr, 20'hA5677);

    // R2: single pulse gives single valid
    req = 1'b0;
    @(negedge clk);
    check("R2 single pulse low", {19'd0, valid}, 20'd0);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 async reset addr", addr, 20'd0);
    check("R1 async reset valid", {19'd0, valid}, 20'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule